// File: doc/BRIEF.md
# Involutional Cipher Round Loop

This block is the iterative datapath of a 64-bit block cipher. Every layer of the cipher is its own inverse. One round is built in hardware and reused. The round is split across two register stages, so two independent blocks share it, each one sitting in one stage and swapping stages every cycle. Each block travels with its own direction flag. The round keys are fed from outside, one per cycle, on a single key port. The surrounding key scheduler knows from the fixed timing which block and which round each key belongs to.

A block is offered as plaintext (or ciphertext) together with its whitening key. That key is XORed in as the block is captured. The block then makes 15 full trips around the loop and one final, shortened trip. After that it appears on the output with a one-cycle valid pulse. Decryption uses exactly the same logic as encryption. Only the key sequence changes, so the direction may change from one block to the next. The 4-bit substitution tables and the wire permutations are parameters. The defaults listed below are all involutions.

Top module: `invol_cipher_loop`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0 and `inReady` is 1.
- R2: The substitution layer works on each byte independently (byte b is bits 8b+7..8b, high nibble in bits 7..4). It applies the first table to both nibbles, then the byte wiring, then the second table to both nibbles, then the byte wiring again, then the first table again. A table holds entry n at bits 4n+3..4n. The defaults are 64'h470A1C53E29F86BD for the first table and 64'h289361DE5B70CFA4 for the second. The wiring sets out[i] = in[m(i)], with m = 5,6,7,4,3,0,1,2 for i = 0..7.
- R3: A full round follows the substitution layer with a diffusion layer, taken in this order: (1) the 64-bit wiring out[i] = in[j], where j is i with its upper and lower 3-bit halves swapped; (2) per nibble, y3=x2^x1^x0, y2=x3^x1^x0, y1=x3^x2^x0, y0=x3^x2^x1; (3) XOR with `roundKey`; (4) per nibble, out[i] = in[m(i)] with m = 1,0,3,2; (5) the 64-bit wiring again.
- R4: The result is built as follows. Take `dataIn` XOR `whiteKey`. Apply 15 full rounds using round keys K1..K15. Then apply the substitution layer alone and XOR with K16.
- R5: For a block captured at rising edge n, key Kk (k = 1..16) is sampled from `roundKey` at edge n+2k. `roundKey` is ignored at every other edge.
- R6: A block captured at edge n is presented on `dataOut` with `outValid` high in exactly the one cycle after edge n+33. `outDecrypt` then repeats the block's `inDecrypt`.
- R7: Decryption needs no mode logic. Feed the ciphertext with whitening key K16, then round keys P(D(K15)) .. P(D(K1)) using the nibble maps of R3, then K0 as the last key. This returns the plaintext.
- R8: `inReady` is low exactly while the stage that a new block would enter next cycle is still in use by a block that has rounds left. An offer made while `inReady` is low is discarded and produces no output.
- R9: Two blocks may be captured on consecutive edges. With a continuous supply of blocks, the block offered third is captured exactly 32 edges after the first, in the cycle its slot finishes, and so on for every later block.
- R10: The direction may change on every block. Blocks of opposite directions in flight together do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A block is offered this cycle |
| inDecrypt | input | 1 | Direction tag travelling with the offered block |
| dataIn | input | 64 | Offered block |
| whiteKey | input | 64 | Whitening key XORed in on capture |
| inReady | output | 1 | An offer made this cycle is captured |
| roundKey | input | 64 | Round key for the block in the second stage |
| outValid | output | 1 | Result pulse |
| outDecrypt | output | 1 | Direction tag of the result |
| dataOut | output | 64 | Finished block |

## Verification
The first inputs are an all-zero block under all-zero keys and an all-ones block under all-ones keys. Together they show whether the substitution tables and the diffusion boxes map fixed patterns correctly. Random blocks under random key sets are then checked against an arithmetic model of the cipher. Each random block is also run back through the decryption key order, which tells whether the rounds truly invert regardless of the model. Blocks are streamed with the direction alternating on every block while offers are held during busy cycles. This tells apart a correct slot hand-over from a wrongly accepted, lost or cross-contaminated block, and fixes the exact capture spacing and latency.

// File: rtl/icl_pkg.sv
package icl_pkg;

  localparam int CNT_W = 5;

  typedef struct packed {
    logic             valid;
    logic             decrypt;
    logic [CNT_W-1:0] cnt;
  } slot_t;

  typedef struct packed {
    logic takeIn;     // capture offered block
    logic useNew;     // first stage takes captured block instead of loop
    logic lastRound;  // second stage skips diffusion
    logic takeOut;    // result register loads
  } strobe_t;

  // Default 64-bit wiring: swap the two 3-bit halves of the bit index.
  function automatic logic [64*6-1:0] halfSwapMap();
    logic [64*6-1:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] k;
      k = 6'(i);
      m[6*i +: 6] = {k[2:0], k[5:3]};
    end
    return m;
  endfunction

endpackage

// File: rtl/icl_subst_layer.sv
module icl_subst_layer #(
  parameter int          BLOCK_W = 64,
  parameter logic [63:0] S0_TAB  = 64'h470A1C53E29F86BD,
  parameter logic [63:0] S1_TAB  = 64'h289361DE5B70CFA4,
  parameter logic [23:0] P8_MAP  = 24'h4439F5
) (
  input  logic [BLOCK_W-1:0] din,
  output logic [BLOCK_W-1:0] dout
);

  localparam int NBYTES = BLOCK_W / 8;

  function automatic logic [3:0] sbox0(input logic [3:0] x);
    return S0_TAB[{x, 2'b00} +: 4];
  endfunction

  function automatic logic [3:0] sbox1(input logic [3:0] x);
    return S1_TAB[{x, 2'b00} +: 4];
  endfunction

  function automatic logic [7:0] wire8(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = x[P8_MAP[3*i +: 3]];
    return y;
  endfunction

  function automatic logic [7:0] byteMap(input logic [7:0] x);
    logic [7:0] t;
    t = {sbox0(x[7:4]), sbox0(x[3:0])};
    t = wire8(t);
    t = {sbox1(t[7:4]), sbox1(t[3:0])};
    t = wire8(t);
    return {sbox0(t[7:4]), sbox0(t[3:0])};
  endfunction

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[8*b +: 8] = byteMap(din[8*b +: 8]);
  end

endmodule

// File: rtl/icl_diffuse_layer.sv
module icl_diffuse_layer #(
  parameter int                                 BLOCK_W = 64,
  parameter logic [7:0]                         P4_MAP  = 8'hB1,
  parameter logic [BLOCK_W*$clog2(BLOCK_W)-1:0] P64_MAP = icl_pkg::halfSwapMap()
) (
  input  logic [BLOCK_W-1:0] din,
  input  logic [BLOCK_W-1:0] key,
  output logic [BLOCK_W-1:0] dout
);

  localparam int IDX_W = $clog2(BLOCK_W);
  localparam int NNIB  = BLOCK_W / 4;

  logic [BLOCK_W-1:0] spread, mixed, keyed, swapped;

  // every output bit is the parity of the other three inputs
  function automatic logic [3:0] dbox(input logic [3:0] x);
    return {x[2] ^ x[1] ^ x[0], x[3] ^ x[1] ^ x[0],
            x[3] ^ x[2] ^ x[0], x[3] ^ x[2] ^ x[1]};
  endfunction

  always_comb begin
    for (int i = 0; i < BLOCK_W; i++) spread[i] = din[P64_MAP[IDX_W*i +: IDX_W]];
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    assign mixed[4*n +: 4] = dbox(spread[4*n +: 4]);
    assign keyed[4*n +: 4] = mixed[4*n +: 4] ^ key[4*n +: 4];
    for (genvar b = 0; b < 4; b++) begin : g_bit
      assign swapped[4*n + b] = keyed[4*n + int'(P4_MAP[2*b +: 2])];
    end
  end

  always_comb begin
    for (int i = 0; i < BLOCK_W; i++) dout[i] = swapped[P64_MAP[IDX_W*i +: IDX_W]];
  end

endmodule

// File: rtl/icl_datapath.sv
module icl_datapath import icl_pkg::*; #(
  parameter int                                 BLOCK_W = 64,
  parameter logic [63:0]                        S0_TAB  = 64'h470A1C53E29F86BD,
  parameter logic [63:0]                        S1_TAB  = 64'h289361DE5B70CFA4,
  parameter logic [23:0]                        P8_MAP  = 24'h4439F5,
  parameter logic [7:0]                         P4_MAP  = 8'hB1,
  parameter logic [BLOCK_W*$clog2(BLOCK_W)-1:0] P64_MAP = icl_pkg::halfSwapMap()
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [BLOCK_W-1:0] whiteKey,
  input  logic [BLOCK_W-1:0] roundKey,
  output logic [BLOCK_W-1:0] dataOut
);

  logic [BLOCK_W-1:0] inReg, aReg, bReg, outReg;
  logic [BLOCK_W-1:0] aIn, substOut, diffOut, bIn;

  assign aIn = strobe.useNew ? inReg : bReg;

  icl_subst_layer #(
    .BLOCK_W(BLOCK_W), .S0_TAB(S0_TAB), .S1_TAB(S1_TAB), .P8_MAP(P8_MAP)
  ) u_subst (
    .din (aIn),
    .dout(substOut)
  );

  icl_diffuse_layer #(
    .BLOCK_W(BLOCK_W), .P4_MAP(P4_MAP), .P64_MAP(P64_MAP)
  ) u_diffuse (
    .din (aReg),
    .key (roundKey),
    .dout(diffOut)
  );

  // final trip: substitution already done in stage one, only key addition here
  assign bIn = strobe.lastRound ? (aReg ^ roundKey) : diffOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      aReg   <= '0;
      bReg   <= '0;
      outReg <= '0;
    end else begin
      if (strobe.takeIn) inReg <= dataIn ^ whiteKey;
      aReg <= substOut;
      bReg <= bIn;
      if (strobe.takeOut) outReg <= bReg;
    end
  end

  assign dataOut = outReg;

endmodule

// File: rtl/icl_ctrl.sv
module icl_ctrl import icl_pkg::*; #(
  parameter int KEY_ADDS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inDecrypt,
  output logic    inReady,
  output strobe_t strobe,
  output logic    outValid,
  output logic    outDecrypt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_ADDS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic  inValidQ, inDecQ;
  slot_t aSlot, bSlot, aNext;
  logic  accept, bLive, bDone;
  logic  outValidQ, outDecQ;

  // the slot reaching stage one next cycle is the one now in stage one
  assign inReady = !(aSlot.valid && aSlot.cnt != LAST);
  assign accept  = inValid && inReady;
  assign bLive   = bSlot.valid && bSlot.cnt != LAST;
  assign bDone   = bSlot.valid && bSlot.cnt == LAST;

  always_comb begin
    aNext = '0;
    if (inValidQ) begin
      aNext.valid   = 1'b1;
      aNext.decrypt = inDecQ;
      aNext.cnt     = ONE;
    end else if (bLive) begin
      aNext.valid   = 1'b1;
      aNext.decrypt = bSlot.decrypt;
      aNext.cnt     = bSlot.cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inValidQ  <= 1'b0;
      inDecQ    <= 1'b0;
      aSlot     <= '0;
      bSlot     <= '0;
      outValidQ <= 1'b0;
      outDecQ   <= 1'b0;
    end else begin
      inValidQ  <= accept;
      inDecQ    <= accept & inDecrypt;
      aSlot     <= aNext;
      bSlot     <= aSlot;
      outValidQ <= bDone;
      if (bDone) outDecQ <= bSlot.decrypt;
    end
  end

  always_comb begin
    strobe.takeIn    = accept;
    strobe.useNew    = inValidQ;
    strobe.lastRound = aSlot.cnt == LAST;
    strobe.takeOut   = bDone;
  end

  assign outValid   = outValidQ;
  assign outDecrypt = outDecQ;

  p_no_collision_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValidQ |-> !bLive);

  p_drop_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |=> !inValidQ);

  p_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValidQ |=> (aSlot.valid && aSlot.cnt == ONE && aSlot.decrypt == $past(inDecQ)));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    aSlot.valid |-> (aSlot.cnt >= ONE && aSlot.cnt <= LAST));

  p_loop_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    bLive |=> (aSlot.valid && aSlot.cnt == $past(bSlot.cnt) + ONE));

  p_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(aSlot.valid, 2) && $past(aSlot.cnt, 2) == LAST));

endmodule

// File: rtl/invol_cipher_loop.sv
module invol_cipher_loop import icl_pkg::*; #(
  parameter int                                 BLOCK_W  = 64,
  parameter int                                 KEY_ADDS = 16,
  parameter logic [63:0]                        S0_TAB   = 64'h470A1C53E29F86BD,
  parameter logic [63:0]                        S1_TAB   = 64'h289361DE5B70CFA4,
  parameter logic [23:0]                        P8_MAP   = 24'h4439F5,
  parameter logic [7:0]                         P4_MAP   = 8'hB1,
  parameter logic [BLOCK_W*$clog2(BLOCK_W)-1:0] P64_MAP  = icl_pkg::halfSwapMap()
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inDecrypt,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [BLOCK_W-1:0] whiteKey,
  output logic               inReady,
  input  logic [BLOCK_W-1:0] roundKey,
  output logic               outValid,
  output logic               outDecrypt,
  output logic [BLOCK_W-1:0] dataOut
);

  strobe_t strobe;

  icl_ctrl #(.KEY_ADDS(KEY_ADDS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inDecrypt (inDecrypt),
    .inReady   (inReady),
    .strobe    (strobe),
    .outValid  (outValid),
    .outDecrypt(outDecrypt)
  );

  icl_datapath #(
    .BLOCK_W(BLOCK_W), .S0_TAB(S0_TAB), .S1_TAB(S1_TAB),
    .P8_MAP(P8_MAP), .P4_MAP(P4_MAP), .P64_MAP(P64_MAP)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .whiteKey(whiteKey),
    .roundKey(roundKey),
    .dataOut (dataOut)
  );

endmodule

// File: tb/sim_invol_cipher_loop.sv
`timescale 1ns/1ps
module sim_invol_cipher_loop;

  localparam int NJOB = 26;
  localparam int LAT  = 33;
  localparam logic [63:0] TAB0 = 64'h470A1C53E29F86BD;
  localparam logic [63:0] TAB1 = 64'h289361DE5B70CFA4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inDecrypt = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] whiteKey = '0;
  logic [63:0] roundKey = '0;
  logic        inReady, outValid, outDecrypt;
  logic [63:0] dataOut;

  invol_cipher_loop u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDecrypt(inDecrypt),
    .dataIn(dataIn), .whiteKey(whiteKey), .inReady(inReady),
    .roundKey(roundKey), .outValid(outValid), .outDecrypt(outDecrypt),
    .dataOut(dataOut)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int outCount = 0;

  logic [63:0] jobData [NJOB];
  logic [63:0] jobKeys [NJOB][17];
  logic        jobDec  [NJOB];
  logic [63:0] jobExp  [NJOB];
  int          acceptEdge [NJOB];

  bit entUsed [4];
  int entN    [4];
  int entJob  [4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 model
  function automatic logic [3:0] sb(input logic [63:0] tab, input logic [3:0] x);
    return tab[4*int'(x) +: 4];
  endfunction

  function automatic logic [7:0] w8(input logic [7:0] x);
    int m [8] = '{5, 6, 7, 4, 3, 0, 1, 2};
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = x[m[i]];
    return y;
  endfunction

  function automatic logic [63:0] substM(input logic [63:0] s);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      logic [7:0] t;
      t = s[8*b +: 8];
      t = {sb(TAB0, t[7:4]), sb(TAB0, t[3:0])};
      t = w8(t);
      t = {sb(TAB1, t[7:4]), sb(TAB1, t[3:0])};
      t = w8(t);
      r[8*b +: 8] = {sb(TAB0, t[7:4]), sb(TAB0, t[3:0])};
    end
    return r;
  endfunction

  // R3 model
  function automatic logic [63:0] w64(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[i] = x[((i % 8) * 8) + (i / 8)];
    return y;
  endfunction

  function automatic logic [3:0] dmix(input logic [3:0] x);
    logic p;
    p = ^x;
    return {4{p}} ^ x;
  endfunction

  function automatic logic [3:0] w4(input logic [3:0] x);
    return {x[2], x[3], x[0], x[1]};
  endfunction

  function automatic logic [63:0] diffM(input logic [63:0] x, input logic [63:0] k);
    logic [63:0] t;
    t = w64(x);
    for (int n = 0; n < 16; n++) t[4*n +: 4] = dmix(t[4*n +: 4]);
    t = t ^ k;
    for (int n = 0; n < 16; n++) t[4*n +: 4] = w4(t[4*n +: 4]);
    return w64(t);
  endfunction

  // R7 key transform
  function automatic logic [63:0] invKey(input logic [63:0] k);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = dmix(w4(k[4*n +: 4]));
    return r;
  endfunction

  // R4 full cipher model
  function automatic logic [63:0] cipherM(input int j);
    logic [63:0] s;
    s = jobData[j] ^ jobKeys[j][0];
    for (int r = 1; r <= 15; r++) s = diffM(substM(s), jobKeys[j][r]);
    return substM(s) ^ jobKeys[j][16];
  endfunction

  task automatic makePair(input int j, input logic [63:0] pt, input int kind);
    jobData[j] = pt;
    jobDec[j]  = 1'b0;
    for (int r = 0; r <= 16; r++) begin
      if (kind == 0)      jobKeys[j][r] = '0;
      else if (kind == 1) jobKeys[j][r] = '1;
      else                jobKeys[j][r] = {$urandom, $urandom};
    end
    jobExp[j] = cipherM(j);
    jobData[j+1] = jobExp[j];
    jobDec[j+1]  = 1'b1;
    jobExp[j+1]  = pt;
    jobKeys[j+1][0]  = jobKeys[j][16];
    jobKeys[j+1][16] = jobKeys[j][0];
    for (int r = 1; r <= 15; r++) jobKeys[j+1][r] = invKey(jobKeys[j][16-r]);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // key supply, readiness and result checking
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [63:0] rk;
      bit expReady;
      bit hit;
      rk = {$urandom, $urandom};  // R5: junk whenever no key is due
      expReady = 1'b1;
      for (int e = 0; e < 4; e++) begin
        if (entUsed[e]) begin
          int d;
          d = cyc - entN[e];
          if (d >= 1 && d <= 31 && (d % 2) == 1) rk = jobKeys[entJob[e]][(d + 1) / 2];
          if (d >= 1 && d <= 29 && (d % 2) == 1) expReady = 1'b0;
        end
      end
      roundKey = rk;
      chk(inReady == expReady, "R8 ready", 64'(inReady), 64'(expReady));
      if (outValid) begin
        hit = 1'b0;
        for (int e = 0; e < 4; e++) begin
          if (entUsed[e] && !hit && entN[e] + LAT == cyc) begin
            int j;
            j = entJob[e];
            hit = 1'b1;
            entUsed[e] = 1'b0;
            outCount++;
            if (jobDec[j]) chk(dataOut == jobExp[j], "R7 decrypt round trip", dataOut, jobExp[j]);
            else           chk(dataOut == jobExp[j], "R2/R3/R4 encrypt", dataOut, jobExp[j]);
            chk(outDecrypt == jobDec[j], "R10 direction tag", 64'(outDecrypt), 64'(jobDec[j]));
          end
        end
        if (!hit) chk(1'b0, "R6 unexpected result", dataOut, '0);
      end
      for (int e = 0; e < 4; e++) begin
        if (entUsed[e] && cyc > entN[e] + LAT) begin
          entUsed[e] = 1'b0;
          chk(1'b0, "R6 missing result", '0, jobExp[entJob[e]]);
        end
      end
    end
  end

  initial begin
    for (int e = 0; e < 4; e++) entUsed[e] = 1'b0;
    makePair(0, 64'h0, 0);
    makePair(2, '1, 1);
    for (int j = 4; j < NJOB; j += 2) makePair(j, {$urandom, $urandom}, 2);

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R1 inReady in reset", 64'(inReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", 64'(outValid), 64'd0);

    // continuous supply, direction alternating every block (R9, R10)
    for (int j = 0; j < NJOB; j++) begin
      bit taken;
      taken = 1'b0;
      while (!taken) begin
        @(negedge clk);
        dataIn    = jobData[j];
        whiteKey  = jobKeys[j][0];
        inDecrypt = jobDec[j];
        inValid   = 1'b1;
        if (inReady) begin
          for (int e = 0; e < 4; e++) begin
            if (!taken && !entUsed[e]) begin
              entUsed[e] = 1'b1;
              entN[e]    = cyc + 1;
              entJob[e]  = j;
              taken      = 1'b1;
            end
          end
          acceptEdge[j] = cyc + 1;
        end
      end
    end
    @(negedge clk);
    inValid   = 1'b0;
    dataIn    = {$urandom, $urandom};
    whiteKey  = {$urandom, $urandom};

    repeat (LAT + 8) @(negedge clk);

    chk(outCount == NJOB, "R8 result count", 64'(outCount), 64'(NJOB));
    chk(acceptEdge[1] - acceptEdge[0] == 1, "R9 back-to-back capture",
        64'(acceptEdge[1] - acceptEdge[0]), 64'd1);
    for (int j = 0; j + 2 < NJOB; j++)
      chk(acceptEdge[j+2] - acceptEdge[j] == 32, "R9 slot reuse spacing",
          64'(acceptEdge[j+2] - acceptEdge[j]), 64'd32);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R6 watchdog expired", 64'(outCount), 64'(NJOB));
      finishRun();
    end
  end

endmodule